// File: doc/BRIEF.md
# Burst Column Address Generator

This block steps through the column addresses of one read or write burst in a synchronous DRAM controller. A start strobe loads a starting column, a burst-length code, an ordering bit and a page-width setting. From the next clock on, the block presents one column per cycle, together with a beat-valid flag and a final-beat flag.

Two orderings are supported. Sequential order counts the low bits of the column upward and wraps them inside the burst. Interleaved order forms the low bits by XOR-ing the beat number into the start column. A full-page burst steps around the whole page and keeps going until it is stopped or replaced. A new start strobe is accepted on any clock and restarts the sequence from the new column. A terminate strobe ends the burst.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is active and after it is released with no command, `valid_o` and `last_o` are 0 and `col_o` is 0.
- R2: In the cycle after a clock edge that samples `start_i`=1, `valid_o` is 1 and `col_o` equals `start_col_i`, masked to the page width.
- R3: In sequential order with burst length BL, beat n keeps the column bits above log2(BL) of the start and sets the low log2(BL) bits to (start low bits + n) mod BL.
- R4: When `interleave_i`=1 with a fixed length BL, beat n keeps the upper bits and sets the low log2(BL) bits to (start low bits) XOR n.
- R5: `blen_code_i` encodes the burst length: 0 gives 1 beat, 1 gives 2 beats, 2 gives 4 beats, 3 gives 8 beats, and any code with bit 2 set gives full page. A fixed burst shows exactly BL valid beats, and `valid_o` is 0 in the cycle after the last beat.
- R6: `last_o` is 1 on the final beat of a fixed-length burst and 0 on every other beat.
- R7: A full-page burst advances the column by 1 modulo the page size on each cycle, continues with no limit, and never raises `last_o`.
- R8: When `interleave_i`=1 together with full page, the sequential order is used.
- R9: A start strobe on any cycle, including during a burst or in the same cycle as `stop_i`, restarts the sequence from the new column at beat 0.
- R10: `stop_i`=1 without `start_i` makes `valid_o` and `last_o` 0 from the next cycle.
- R11: `wide_page_i`=0 selects a 512-column page, which uses 9 bits with `col_o[9]` held at 0. `wide_page_i`=1 selects a 1024-column page, which uses 10 bits. The value is sampled with the start strobe.
- R12: `last_o` is never 1 while `valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load a new column and start a burst |
| start_col_i | input | 10 | Starting column |
| blen_code_i | input | 3 | Burst-length code |
| interleave_i | input | 1 | 1 selects interleaved order |
| wide_page_i | input | 1 | 1 selects the 1024-column page, 0 the 512-column page |
| stop_i | input | 1 | Terminate the current burst |
| col_o | output | 10 | Column of the current beat |
| valid_o | output | 1 | A beat is present |
| last_o | output | 1 | The present beat is the final one |

## Verification
A single register stage lies between a start strobe and its first beat, so beat n appears n+1 cycles after the edge that samples the strobe. A stop takes effect one cycle after its edge, and the cycle after a final beat shows `valid_o` low. The bench drives inputs on falling edges and reads the outputs on the next falling edge, half a period after the register update. It advances its reference beat index by one for each falling edge it waits. Restart cases issue the new strobe while beats are still coming and expect beat 0 of the new burst on the very next read.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
   typedef enum logic [2:0] {
      BLC_ONE   = 3'd0,
      BLC_TWO   = 3'd1,
      BLC_FOUR  = 3'd2,
      BLC_EIGHT = 3'd3
   } blen_code_t;
endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode
   import burst_col_pkg::*;
#(
   parameter int COL_W = 10
) (
   input  logic [2:0]       code_i,
   input  logic [COL_W-1:0] page_mask_i,
   output logic [COL_W-1:0] low_mask_o,
   output logic             full_o
);
   initial begin
      if (COL_W < 3) $error("burst_len_decode: COL_W must cover an 8-beat burst");
   end

   always_comb begin
      full_o     = code_i[2];
      low_mask_o = page_mask_i;
      if (!code_i[2]) begin
         case (blen_code_t'(code_i))
            BLC_ONE:   low_mask_o = COL_W'(0);
            BLC_TWO:   low_mask_o = COL_W'(1);
            BLC_FOUR:  low_mask_o = COL_W'(3);
            BLC_EIGHT: low_mask_o = COL_W'(7);
            default:   low_mask_o = page_mask_i;
         endcase
      end
   end
endmodule

// File: rtl/col_addr_calc.sv
module col_addr_calc #(
   parameter int COL_W         = 10,
   parameter bit INTERLEAVE_EN = 1'b1
) (
   input  logic [COL_W-1:0] base_i,
   input  logic [COL_W-1:0] beat_i,
   input  logic [COL_W-1:0] low_mask_i,
   input  logic [COL_W-1:0] page_mask_i,
   input  logic             use_il_i,
   output logic [COL_W-1:0] col_o
);
   logic [COL_W-1:0] offs;

   generate
      if (INTERLEAVE_EN) begin : g_both_orders
         always_comb offs = use_il_i ? (base_i ^ beat_i) : (base_i + beat_i);
      end else begin : g_seq_only
         logic unused_il;
         assign unused_il = use_il_i;
         always_comb offs = base_i + beat_i;
      end
   endgenerate

   always_comb col_o = ((base_i & ~low_mask_i) | (offs & low_mask_i)) & page_mask_i;
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
   parameter int WIDE_W        = 10,
   parameter int NARROW_W      = 9,
   parameter bit INTERLEAVE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [WIDE_W-1:0] start_col_i,
   input  logic [2:0]        blen_code_i,
   input  logic              interleave_i,
   input  logic              wide_page_i,
   input  logic              stop_i,
   output logic [WIDE_W-1:0] col_o,
   output logic              valid_o,
   output logic              last_o
);
   localparam logic [WIDE_W-1:0] WIDE_MASK   = {WIDE_W{1'b1}};
   localparam logic [WIDE_W-1:0] NARROW_MASK = WIDE_W'((64'd1 << NARROW_W) - 64'd1);

   initial begin
      if (NARROW_W >= WIDE_W) $error("burst_col_gen: NARROW_W must be below WIDE_W");
      if (NARROW_W < 3)       $error("burst_col_gen: NARROW_W must cover an 8-beat burst");
   end

   logic [WIDE_W-1:0] in_page_mask, in_low_mask;
   logic              in_full;

   logic [WIDE_W-1:0] base_q, beat_q, low_mask_q, page_mask_q;
   logic              full_q, il_q, active_q;
   logic              at_end;

   always_comb in_page_mask = wide_page_i ? WIDE_MASK : NARROW_MASK;

   burst_len_decode #(.COL_W(WIDE_W)) u_decode (
      .code_i      (blen_code_i),
      .page_mask_i (in_page_mask),
      .low_mask_o  (in_low_mask),
      .full_o      (in_full)
   );

   always_comb at_end = active_q && !full_q && (beat_q == low_mask_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q      <= '0;
         beat_q      <= '0;
         low_mask_q  <= '0;
         page_mask_q <= '0;
         full_q      <= 1'b0;
         il_q        <= 1'b0;
         active_q    <= 1'b0;
      end else if (start_i) begin
         base_q      <= start_col_i & in_page_mask;
         beat_q      <= '0;
         low_mask_q  <= in_low_mask;
         page_mask_q <= in_page_mask;
         full_q      <= in_full;
         il_q        <= interleave_i & ~in_full;
         active_q    <= 1'b1;
      end else if (stop_i || at_end) begin
         active_q    <= 1'b0;
      end else if (active_q) begin
         beat_q      <= beat_q + 1'b1;
      end
   end

   logic [WIDE_W-1:0] calc_col;

   col_addr_calc #(.COL_W(WIDE_W), .INTERLEAVE_EN(INTERLEAVE_EN)) u_calc (
      .base_i      (base_q),
      .beat_i      (beat_q),
      .low_mask_i  (low_mask_q),
      .page_mask_i (page_mask_q),
      .use_il_i    (il_q),
      .col_o       (calc_col)
   );

   assign col_o   = active_q ? calc_col : '0;
   assign valid_o = active_q;
   assign last_o  = at_end;

   p_last_needs_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
      last_o |-> valid_o);
   p_start_gives_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> valid_o);
   p_stop_ends_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_i && !start_i) |=> (!valid_o && !last_o));
   p_after_last_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (last_o && !start_i) |=> !valid_o);
   p_full_no_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && full_q) |-> !last_o);
   p_narrow_top_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && (page_mask_q == NARROW_MASK)) |-> ((col_o & ~NARROW_MASK) == '0));
   p_full_steps_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && full_q && !start_i && !stop_i) |=>
         (col_o == ((($past(col_o) + 1'b1)) & page_mask_q)));
endmodule

// File: tb/tb_burst_col_gen.sv
module tb_burst_col_gen;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic [9:0] start_col_i = '0;
   logic [2:0] blen_code_i = '0;
   logic       interleave_i = 1'b0;
   logic       wide_page_i = 1'b0;
   logic       stop_i = 1'b0;
   logic [9:0] col_o;
   logic       valid_o, last_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   int m_base, m_code, m_il, m_wide, m_n;

   always #(CLK_PERIOD/2) clk = ~clk;

   burst_col_gen dut (
      .clk, .rst_n, .start_i, .start_col_i, .blen_code_i, .interleave_i,
      .wide_page_i, .stop_i, .col_o, .valid_o, .last_o
   );

   function automatic int page_sz(int wide);
      return wide ? 1024 : 512;
   endfunction

   function automatic int blen(int code, int wide);
      return (code >= 4) ? page_sz(wide) : (1 << code);
   endfunction

   function automatic int exp_col(int n);
      int pg, b, bl, lo;
      pg = page_sz(m_wide);
      b  = m_base % pg;
      bl = blen(m_code, m_wide);
      if (m_code >= 4) return (b + n) % pg;
      lo = b % bl;
      if (m_il) return (b - lo) + (lo ^ (n % bl));
      return (b - lo) + ((lo + n) % bl);
   endfunction

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // called at a falling edge; returns at the falling edge where beat 0 is visible
   task automatic cmd(int base, int code, int il, int wide, bit with_stop);
      start_i = 1'b1; start_col_i = 10'(base); blen_code_i = 3'(code);
      interleave_i = il[0]; wide_page_i = wide[0]; stop_i = with_stop;
      m_base = base; m_code = code; m_il = (code >= 4) ? 0 : il; m_wide = wide; m_n = 0;
      @(negedge clk);
      start_i = 1'b0; stop_i = 1'b0;
   endtask

   task automatic beat(string req);
      bit fixed_last;
      fixed_last = (m_code < 4) && (m_n == blen(m_code, m_wide) - 1);
      check(req, valid_o, 1);
      check(req, col_o, exp_col(m_n));
      check(req, last_o, fixed_last);
      @(negedge clk);
      m_n++;
   endtask

   task automatic idle(string req);
      check(req, valid_o, 0);
      check(req, last_o, 0);
   endtask

   task automatic t_reset;
      check("R1 valid", valid_o, 0);
      check("R1 last", last_o, 0);
      check("R1 col", col_o, 0);
   endtask

   task automatic t_fixed(int base, int code, int il, int wide, string req);
      cmd(base, code, il, wide, 1'b0);
      for (int i = 0; i < blen(code, wide); i++) beat(req);
      idle("R5 end of burst");
   endtask

   task automatic t_full(int base, int il, int wide, int n, string req);
      cmd(base, 7, il, wide, 1'b0);
      for (int i = 0; i < n; i++) beat(req);
      stop_i = 1'b1;
      @(negedge clk);
      stop_i = 1'b0;
      idle("R10 stop");
   endtask

   task automatic t_restart;
      cmd(10'h010, 3, 0, 0, 1'b0);
      beat("R9 first burst");
      beat("R9 first burst");
      cmd(10'h025, 2, 1, 0, 1'b0);
      for (int i = 0; i < 4; i++) beat("R9 restarted burst");
      idle("R9 end");
   endtask

   task automatic t_start_with_stop;
      cmd(10'h033, 1, 0, 1, 1'b1);
      beat("R9 start beats stop");
      beat("R9 start beats stop");
      idle("R9 end");
   endtask

   task automatic t_every_clock;
      for (int k = 0; k < 4; k++) begin
         cmd(10'h100 + k * 7, 3, 0, 1, 1'b0);
         check("R9 each clock", col_o, exp_col(0));
         check("R9 each clock valid", valid_o, 1);
      end
      @(negedge clk);
      m_n = 1;
      beat("R9 continues after last start");
      stop_i = 1'b1; @(negedge clk); stop_i = 1'b0;
      idle("R10 stop");
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      stop_i = 1'b1; @(negedge clk); stop_i = 1'b0;
      idle("R10 stop while idle");
      t_fixed(10'h0D5, 3, 0, 0, "R3 sequential BL8");
      t_fixed(10'h0D5, 3, 1, 0, "R4 interleaved BL8");
      t_fixed(10'h2C6, 2, 0, 1, "R3 sequential BL4");
      t_fixed(10'h2C6, 2, 1, 1, "R4 interleaved BL4");
      t_fixed(10'h0AB, 1, 0, 0, "R5 BL2");
      t_fixed(10'h0AB, 0, 1, 0, "R6 BL1 last on beat 0");
      t_fixed(10'h3C7, 3, 0, 0, "R11 narrow page masks start");
      t_full(10'h1FD, 0, 0, 6, "R7 full page narrow wrap");
      t_full(10'h3FE, 1, 1, 5, "R8 full page ignores interleave");
      t_full(10'h200, 0, 1, 3, "R11 wide page keeps bit 9");
      t_restart();
      t_start_with_stop();
      t_every_clock();
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule